// File: doc/BRIEF.md
# Critical-Region Preload-and-Lock Sequencer

This block sits next to a cache whose lines can be pinned, and makes sure that a software-chosen address window is resident and pinned before a sensitive routine runs. Software sets a base address, a byte length and an owner tag, then issues a lock command. The sequencer walks every 64-byte line that the window touches, lowest address first. For each line it sends one request to the cache, and waits for the answer before it sends the next.

The same stored window is used to release the pins. This happens when software asks for it after the sensitive routine, and also when the owning process is switched out, so that other processes get the capacity back. When the owner is switched back in, the whole window is fetched and pinned again, because parts of it may have been evicted in the meantime. A lock refusal from the cache aborts the walk and raises an error flag. Lines that were already pinned stay pinned until a release sweep clears them.

Top module: `plk_preload_lock`

## Requirements
- R1: An accepted lock command (cmd_op_i = 0) captures cfg_base_i, cfg_len_i and cfg_owner_i. It then issues one request with req_lock_o = 1 for each 64-byte line, from the line that holds the base address up to the line that holds base+len-1, in ascending order. Each req_addr_o has its low 6 bits zero, and req_owner_o carries the captured owner.
- R2: A request holds req_valid_o, req_addr_o and req_lock_o steady until req_ready_i. No new request appears until rsp_valid_i answers the previous one, so at most one request is outstanding.
- R3: busy_o goes high in the cycle after a non-empty command is accepted. It stays high until the response to the final line is taken. done_o is high for exactly one cycle, the cycle after that final response, and busy_o is low in that cycle.
- R4: A release command (cmd_op_i = 1) sweeps the stored window with req_lock_o = 0. Current cfg_* values are ignored.
- R5: A switch-out command (cmd_op_i = 2) performs the same release sweep of the stored window, using the stored owner.
- R6: A switch-in command (cmd_op_i = 3) performs a full lock sweep (req_lock_o = 1) of the stored window, using the stored owner.
- R7: During a lock sweep, rsp_valid_i with rsp_fail_i = 1 ends the sweep. error_o goes high, done_o does not pulse, and no further requests are issued. error_o clears when the next command is accepted. rsp_fail_i has no effect during release sweeps.
- R8: A command presented while busy_o is high is ignored. It causes no extra request and does not change the sweep in progress.
- R9: A lock command with zero length issues no request. It keeps busy_o low and pulses done_o in the cycle after acceptance.
- R10: During and right after reset, busy_o, done_o, error_o and req_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_base_i | input | AW | Window start byte address |
| cfg_len_i | input | LW | Window length in bytes |
| cfg_owner_i | input | IW | Owner tag for the window |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 0 lock, 1 release, 2 switch-out, 3 switch-in |
| req_valid_o | output | 1 | Cache request valid |
| req_ready_i | input | 1 | Cache accepts request |
| req_addr_o | output | AW | Line-aligned request address |
| req_lock_o | output | 1 | 1 load-and-pin, 0 unpin |
| req_owner_o | output | IW | Owner tag of the request |
| rsp_valid_i | input | 1 | Cache response for the outstanding request |
| rsp_fail_i | input | 1 | Line could not be pinned |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle sweep completion pulse |
| error_o | output | 1 | Last lock sweep was refused |

## Verification
A corrupted line counter shows up at the first handshake after the fault, as a skipped, repeated or unaligned req_addr_o. The request count also comes out wrong by the end of the sweep. A sequencer state that loses track of the outstanding response shows up within one cycle, as a second request before rsp_valid_i or as a busy_o level that disagrees with req_valid_o. A wrong stored window or owner is caught on the first request of a release or switch-in sweep. A mishandled refusal shows up in the cycle after the failing response, as a further request or a done_o pulse.

// File: rtl/plk_pkg.sv
package plk_pkg;
  typedef enum logic [1:0] {
    OP_LOCK    = 2'd0,
    OP_RELEASE = 2'd1,
    OP_SWOUT   = 2'd2,
    OP_SWIN    = 2'd3
  } cmd_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/plk_span.sv
module plk_span #(
  parameter int AW  = 32,
  parameter int LW  = 16,
  parameter int OFF = 6,
  localparam int LIX = AW - OFF
) (
  input  logic [AW-1:0]  base_i,
  input  logic [LW-1:0]  len_i,
  output logic [LIX-1:0] first_o,
  output logic [LIX-1:0] last_o,
  output logic           empty_o
);
  logic [AW-1:0] end_addr;

  always_comb begin
    end_addr = base_i + AW'(len_i) - AW'(1);
    first_o  = base_i[AW-1:OFF];
    last_o   = end_addr[AW-1:OFF];
    empty_o  = (len_i == '0);
  end
endmodule

// File: rtl/plk_seq.sv
module plk_seq
  import plk_pkg::*;
#(
  parameter int AW  = 32,
  parameter int OFF = 6,
  localparam int LIX = AW - OFF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           lock_i,
  input  logic           empty_i,
  input  logic [LIX-1:0] first_i,
  input  logic [LIX-1:0] last_i,
  output logic           req_valid_o,
  input  logic           req_ready_i,
  output logic [AW-1:0]  req_addr_o,
  output logic           req_lock_o,
  input  logic           rsp_valid_i,
  input  logic           rsp_fail_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           error_o
);
  seq_state_e     state_q;
  logic [LIX-1:0] cur_q, last_q;
  logic           lock_q, done_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      last_q  <= '0;
      lock_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            err_q <= 1'b0;
            if (empty_i) begin
              done_q <= 1'b1;
            end else begin
              cur_q   <= first_i;
              last_q  <= last_i;
              lock_q  <= lock_i;
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: if (req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: begin
          if (rsp_valid_i) begin
            if (lock_q && rsp_fail_i) begin
              err_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else if (cur_q == last_q) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              cur_q   <= cur_q + LIX'(1);
              state_q <= ST_ISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid_o = (state_q == ST_ISSUE);
  assign req_addr_o  = {cur_q, {OFF{1'b0}}};
  assign req_lock_o  = lock_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign error_o     = err_q;
endmodule

// File: rtl/plk_preload_lock.sv
module plk_preload_lock
  import plk_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LW         = 16,
  parameter int IW         = 8,
  parameter int LINE_BYTES = 64,
  localparam int OFF = $clog2(LINE_BYTES),
  localparam int LIX = AW - OFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] cfg_base_i,
  input  logic [LW-1:0] cfg_len_i,
  input  logic [IW-1:0] cfg_owner_i,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_op_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic [AW-1:0] req_addr_o,
  output logic          req_lock_o,
  output logic [IW-1:0] req_owner_o,
  input  logic          rsp_valid_i,
  input  logic          rsp_fail_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          error_o
);
  cmd_op_e        op;
  logic           accept, is_lock_cmd;
  logic [AW-1:0]  base_q, sel_base;
  logic [LW-1:0]  len_q, sel_len;
  logic [IW-1:0]  owner_q;
  logic [LIX-1:0] first_l, last_l;
  logic           empty_l;

  assign op          = cmd_op_e'(cmd_op_i);
  assign accept      = cmd_valid_i && !busy_o;
  assign is_lock_cmd = (op == OP_LOCK);

  // lock command uses live config, others replay the stored window
  assign sel_base = is_lock_cmd ? cfg_base_i : base_q;
  assign sel_len  = is_lock_cmd ? cfg_len_i  : len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      len_q   <= '0;
      owner_q <= '0;
    end else if (accept && is_lock_cmd) begin
      base_q  <= cfg_base_i;
      len_q   <= cfg_len_i;
      owner_q <= cfg_owner_i;
    end
  end

  plk_span #(.AW(AW), .LW(LW), .OFF(OFF)) u_span (
    .base_i  (sel_base),
    .len_i   (sel_len),
    .first_o (first_l),
    .last_o  (last_l),
    .empty_o (empty_l)
  );

  plk_seq #(.AW(AW), .OFF(OFF)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .lock_i      (op == OP_LOCK || op == OP_SWIN),
    .empty_i     (empty_l),
    .first_i     (first_l),
    .last_i      (last_l),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_addr_o  (req_addr_o),
    .req_lock_o  (req_lock_o),
    .rsp_valid_i (rsp_valid_i),
    .rsp_fail_i  (rsp_fail_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .error_o     (error_o)
  );

  assign req_owner_o = owner_q;
endmodule

// File: rtl/plk_chk.sv
module plk_chk #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64,
  localparam int OFF = $clog2(LINE_BYTES)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_o,
  input logic          req_ready_i,
  input logic [AW-1:0] req_addr_o,
  input logic          req_lock_o,
  input logic          rsp_valid_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          error_o
);
  logic          outst_q, have_prev_q;
  logic [AW-1:0] prev_q;
  logic          hs;

  assign hs = req_valid_o && req_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outst_q     <= 1'b0;
      have_prev_q <= 1'b0;
      prev_q      <= '0;
    end else begin
      if (hs) outst_q <= 1'b1;
      else if (rsp_valid_i) outst_q <= 1'b0;
      if (!busy_o) have_prev_q <= 1'b0;
      else if (hs) begin
        have_prev_q <= 1'b1;
        prev_q      <= req_addr_o;
      end
    end
  end

  p_aligned_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_addr_o[OFF-1:0] == '0));

  p_ascending_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && have_prev_q) |-> (req_addr_o == prev_q + AW'(LINE_BYTES)));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o) && $stable(req_lock_o)));

  p_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !outst_q);

  p_req_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> busy_o);

  p_done_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !req_valid_o));

  p_err_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> (!req_valid_o && !done_o));
endmodule

bind plk_preload_lock plk_chk #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_addr_o  (req_addr_o),
  .req_lock_o  (req_lock_o),
  .rsp_valid_i (rsp_valid_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .error_o     (error_o)
);

// File: tb/plk_preload_lock_tb.sv
`timescale 1ns/1ps
module plk_preload_lock_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [15:0] cfg_len = '0;
  logic [7:0]  cfg_owner = '0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic        req_valid, req_ready, req_lock;
  logic [31:0] req_addr;
  logic [7:0]  req_owner;
  logic        rsp_valid, rsp_fail;
  logic        busy, done, error;

  always #4 clk = ~clk;

  plk_preload_lock u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_base_i(cfg_base), .cfg_len_i(cfg_len),
    .cfg_owner_i(cfg_owner), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_addr_o(req_addr),
    .req_lock_o(req_lock), .req_owner_o(req_owner), .rsp_valid_i(rsp_valid),
    .rsp_fail_i(rsp_fail), .busy_o(busy), .done_o(done), .error_o(error)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // cache model
  logic [31:0] log_addr [256];
  logic        log_lock [256];
  logic [7:0]  log_own  [256];
  int          log_n = 0;
  int          mark0 = 0;
  int          fail_idx = -1;
  bit          stall = 0;
  int          rsp_cnt = 0;
  bit          pend_fail = 0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      req_ready <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_fail  <= 1'b0;
      rsp_cnt   <= 0;
    end else begin
      req_ready <= stall ? ~req_ready : 1'b1;
      rsp_valid <= (rsp_cnt == 1);
      rsp_fail  <= (rsp_cnt == 1) && pend_fail;
      if (rsp_cnt != 0) rsp_cnt <= rsp_cnt - 1;
      if (req_valid && req_ready) begin
        log_addr[log_n] <= req_addr;
        log_lock[log_n] <= req_lock;
        log_own[log_n]  <= req_owner;
        pend_fail       <= ((log_n - mark0) == fail_idx);
        log_n           <= log_n + 1;
        rsp_cnt         <= 2;
      end
    end
  end

  // monitors
  int cyc = 0, rsp_cyc = 0, done_cyc = 0, acc_cyc = 0, done_n = 0;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (rsp_valid) rsp_cyc <= cyc;
    if (done) begin
      done_cyc <= cyc;
      done_n   <= done_n + 1;
    end
  end

  logic busy_after, err_after;

  task automatic issue(input logic [1:0] op);
    @(negedge clk);
    cmd_op = op;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    busy_after = busy;
    err_after = error;
    acc_cyc = cyc;
  endtask

  task automatic wait_idle();
    int t = 0;
    @(negedge clk);
    while (busy && t < 2000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 2000) chk("R3 sweep timeout", 32'd1, 32'd0);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_sweep(input string tag, input logic [31:0] first, input int cnt,
                             input logic lk, input logic [7:0] own);
    int bad = 0;
    chk({tag, " count"}, 32'(log_n - mark0), 32'(cnt));
    for (int i = 0; i < cnt; i++) begin
      if (log_addr[mark0+i] !== first + 32'(64*i) || log_lock[mark0+i] !== lk ||
          log_own[mark0+i] !== own) bad++;
    end
    chk({tag, " addr/lock/owner mismatches"}, 32'(bad), 32'd0);
  endtask

  typedef struct packed {
    logic [31:0] base;
    logic [15:0] len;
    logic [31:0] first;
    logic [7:0]  cnt;
    logic        stl;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0000_1000, 16'h0040, 32'h0000_1000, 8'd1, 1'b0},
    '{32'h0000_103F, 16'h0002, 32'h0000_1000, 8'd2, 1'b0},
    '{32'h0000_2000, 16'h0001, 32'h0000_2000, 8'd1, 1'b1},
    '{32'h0000_20C0, 16'h0080, 32'h0000_20C0, 8'd2, 1'b1},
    '{32'h0000_3004, 16'h00BC, 32'h0000_3000, 8'd3, 1'b0},
    '{32'h0000_1010, 16'h0100, 32'h0000_1000, 8'd5, 1'b1}
  };

  initial begin
    int d0;
    // R10 reset state
    repeat (3) @(negedge clk);
    chk("R10 busy in reset", 32'(busy), 0);
    chk("R10 req_valid in reset", 32'(req_valid), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R10 busy after reset", 32'(busy), 0);
    chk("R10 done after reset", 32'(done), 0);
    chk("R10 error after reset", 32'(error), 0);

    // R1/R2/R3 vector walk
    cfg_owner = 8'h5A;
    foreach (VECS[v]) begin
      cfg_base = VECS[v].base;
      cfg_len  = VECS[v].len;
      stall    = VECS[v].stl;
      mark0    = log_n;
      d0       = done_n;
      issue(2'd0);
      chk("R3 busy after accept", 32'(busy_after), 1);
      wait_idle();
      check_sweep("R1 lock sweep", VECS[v].first, int'(VECS[v].cnt), 1'b1, 8'h5A);
      chk("R3 one done pulse", 32'(done_n - d0), 1);
      chk("R3 done cycle after last rsp", 32'(done_cyc), 32'(rsp_cyc + 1));
      chk("R7 no error", 32'(error), 0);
    end
    stall = 0;

    // R4 release uses stored window, ignores live cfg
    cfg_base = 32'hDEAD_0000;
    cfg_len  = 16'h0400;
    mark0 = log_n;
    issue(2'd1);
    wait_idle();
    check_sweep("R4 release sweep", 32'h1000, 5, 1'b0, 8'h5A);

    // R6 switch-in relock, R8 command while busy ignored
    mark0 = log_n;
    d0 = done_n;
    issue(2'd3);
    issue(2'd1);
    chk("R8 still busy", 32'(busy_after), 1);
    wait_idle();
    repeat (10) @(negedge clk);
    check_sweep("R6 switch-in relock (R8 extra cmd)", 32'h1000, 5, 1'b1, 8'h5A);
    chk("R8 one done only", 32'(done_n - d0), 1);

    // R5 switch-out uses stored owner
    cfg_owner = 8'h33;
    mark0 = log_n;
    issue(2'd2);
    wait_idle();
    check_sweep("R5 switch-out release", 32'h1000, 5, 1'b0, 8'h5A);

    // R7 refusal on lock sweep
    cfg_base = 32'h0000_4000;
    cfg_len  = 16'h0100;
    cfg_owner = 8'h77;
    mark0 = log_n;
    fail_idx = 1;
    d0 = done_n;
    issue(2'd0);
    wait_idle();
    repeat (20) @(negedge clk);
    chk("R7 requests stop after refusal", 32'(log_n - mark0), 2);
    chk("R7 error set", 32'(error), 1);
    chk("R7 no done on refusal", 32'(done_n - d0), 0);
    chk("R7 busy low after refusal", 32'(busy), 0);

    // R7 release clears error; fail ignored on release sweep
    mark0 = log_n;
    fail_idx = 0;
    issue(2'd1);
    chk("R7 error cleared on accept", 32'(err_after), 0);
    wait_idle();
    fail_idx = -1;
    check_sweep("R7 release after refusal", 32'h4000, 4, 1'b0, 8'h77);
    chk("R7 fail ignored on release", 32'(error), 0);

    // R9 zero-length lock
    cfg_len = 16'h0000;
    mark0 = log_n;
    d0 = done_n;
    issue(2'd0);
    chk("R9 busy stays low", 32'(busy_after), 0);
    wait_idle();
    chk("R9 no requests", 32'(log_n - mark0), 0);
    chk("R9 one done", 32'(done_n - d0), 1);
    chk("R9 done cycle after accept", 32'(done_cyc), 32'(acc_cyc));

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule